// File: doc/BRIEF.md
# Transmit Staging FIFO with Cut-Through and Store-and-Forward Start

The block buffers transmit bytes between a DMA engine that writes frames and a MAC that drains them. Every stored byte carries an end-of-frame marker, and the block counts how many complete frames it holds. The block decides when the MAC may begin draining the frame at the head. In cut-through mode draining begins once the fill level reaches a threshold chosen by a 3-bit code. In store-and-forward mode draining begins only when the frame's final byte is stored. Checksum insertion needs the whole frame in the buffer, so enabling it forces store-and-forward behaviour.

While a frame is being drained, the MAC pulls one byte per cycle with `rd_ready`. If the MAC pulls while the buffer is empty in the middle of a frame, the block raises a sticky underflow flag, aborts the frame toward the MAC and discards the rest of that frame as the DMA delivers it. A flush request empties the buffer. Its busy status reads 1 for one cycle and then clears by itself. A second-frame option sets whether the DMA may load the next frame while a complete frame is still waiting or draining.

Top module: `txq_fifo`

## Requirements
- R1: After reset `fill_level`, `frame_cnt`, `underflow`, `flush_busy` and `rd_valid` are 0, and `wr_ready` is 1.
- R2: With store-and-forward off and `csum_en` low, an idle block starts a frame and raises `rd_valid` one cycle after `fill_level` first reaches the threshold for `thr_code`: 0→32, 1→64, 2→128, 3→192, 4 to 7→256 bytes. Below the threshold it stays idle unless a complete frame is stored.
- R3: With `store_fwd` high the threshold is ignored. A frame starts only once a byte written with `wr_last` = 1 is stored, and `rd_valid` rises one cycle after that.
- R4: `csum_en` high gives the same start rule as `store_fwd` high, whatever `store_fwd` is.
- R5: Bytes leave in write order, one per cycle while `rd_valid` and `rd_ready` are high. `rd_last` is 1 exactly on a frame's final byte, and `rd_valid` falls after that byte until the next start.
- R6: When `rd_ready` is high during a frame and the buffer is empty, `underflow` sets and stays set until a flush, and `rd_valid` falls. Every later byte of that frame, up to and including its `wr_last` byte, is discarded, and the next frame is stored normally.
- R7: A `flush_req` pulse makes `flush_busy` read 1 for exactly one cycle. During that cycle `wr_ready` and `rd_valid` are 0. After it the buffer is empty, `frame_cnt` is 0 and `underflow` is clear.
- R8: With `osf_en` low, `wr_ready` is 0 while `frame_cnt` is nonzero. With `osf_en` high, a second frame may be written behind a complete one.
- R9: `fill_level` equals the bytes stored, never exceeds DEPTH, and `wr_ready` is 0 when it equals DEPTH.
- R10: `frame_cnt` counts frames whose final byte is stored and not yet drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| store_fwd | input | 1 | 1 selects store-and-forward start |
| thr_code | input | 3 | Cut-through threshold code |
| csum_en | input | 1 | Checksum insertion active; forces store-and-forward |
| osf_en | input | 1 | Allow writing a second frame behind a complete one |
| flush_req | input | 1 | Flush request pulse |
| wr_valid | input | 1 | DMA byte valid |
| wr_data | input | DATA_W | DMA byte |
| wr_last | input | 1 | Byte is the last of its frame |
| wr_ready | output | 1 | Block accepts a byte this cycle |
| rd_ready | input | 1 | MAC takes a byte this cycle |
| rd_valid | output | 1 | A byte of the current frame is available |
| rd_data | output | DATA_W | Byte to the MAC |
| rd_last | output | 1 | Byte is the last of its frame |
| fill_level | output | $clog2(DEPTH+1) | Bytes stored |
| frame_cnt | output | $clog2(DEPTH+1) | Complete frames stored |
| underflow | output | 1 | Sticky underflow flag |
| flush_busy | output | 1 | Flush in progress |

## Verification
A wrong fill count shows within one cycle as `rd_valid` rising one byte early or late at each threshold. The bench sweeps every threshold code at level threshold−1 and at the threshold, so an off-by-one in the count or in the code mapping appears there. A lost or extra end marker shows as a wrong `frame_cnt`, a misplaced `rd_last`, or a store-and-forward frame that never starts or starts too early. A drop state that does not clear shows when the next frame after an underflow fails to arrive. Stale state after a flush appears in the first byte read back after the flush.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int THR_W = 16;

    // Byte threshold selected by the cut-through code.
    function automatic logic [THR_W-1:0] thr_bytes(input logic [2:0] code);
        case (code)
            3'd0:    thr_bytes = 16'd32;
            3'd1:    thr_bytes = 16'd64;
            3'd2:    thr_bytes = 16'd128;
            3'd3:    thr_bytes = 16'd192;
            default: thr_bytes = 16'd256;
        endcase
    endfunction

endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
    parameter int ENT_W = 9,
    parameter int DEPTH = 256,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/txq_start.sv
module txq_start
    import txq_pkg::*;
#(
    parameter int LVL_W = 9
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] frames,
    input  logic [2:0]       thr_code,
    input  logic             sf_eff,
    input  logic             in_frame,
    input  logic             busy,
    output logic             start_ok
);

    logic [THR_W-1:0] lvl_ext;
    logic             thr_hit;
    logic             whole;

    assign lvl_ext = THR_W'(level);
    assign thr_hit = !sf_eff && (lvl_ext >= thr_bytes(thr_code));
    // Any complete frame in store implies the head frame is complete.
    assign whole   = (frames != '0);
    assign start_ok = !in_frame && !busy && (level != '0) && (whole || thr_hit);

endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_fwd,
    input  logic [2:0]        thr_code,
    input  logic              csum_en,
    input  logic              osf_en,
    input  logic              flush_req,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              wr_ready,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [LVL_W-1:0]  fill_level,
    output logic [LVL_W-1:0]  frame_cnt,
    output logic              underflow,
    output logic              flush_busy
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int ENT_W = DATA_W + 1;
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [LVL_W-1:0] level;
        logic [LVL_W-1:0] frames;
        logic             in_frame;
        logic             drop;
        logic             uflow;
        logic             busy;
    } txq_state_t;

    txq_state_t s_q, s_d;

    logic             empty_w;
    logic             full_w;
    logic             sf_eff;
    logic             start_ok;
    logic             wr_fire;
    logic             keep_w;
    logic             pop_w;
    logic             uf_evt;
    logic [ENT_W-1:0] head;

    assign empty_w  = (s_q.level == '0);
    assign full_w   = (s_q.level == LVL_FULL);
    assign sf_eff   = store_fwd | csum_en;
    assign wr_ready = !s_q.busy && !full_w && (osf_en || (s_q.frames == '0));
    assign wr_fire  = wr_valid && wr_ready;
    assign pop_w    = s_q.in_frame && rd_ready && !empty_w && !s_q.busy;
    assign uf_evt   = s_q.in_frame && rd_ready && empty_w && !s_q.busy;
    assign keep_w   = wr_fire && !s_q.drop && !uf_evt;

    txq_mem #(
        .ENT_W (ENT_W),
        .DEPTH (DEPTH)
    ) u_mem (
        .clk   (clk),
        .we    (keep_w),
        .waddr (s_q.wptr),
        .wdata ({wr_last, wr_data}),
        .raddr (s_q.rptr),
        .rdata (head)
    );

    txq_start #(
        .LVL_W (LVL_W)
    ) u_start (
        .level    (s_q.level),
        .frames   (s_q.frames),
        .thr_code (thr_code),
        .sf_eff   (sf_eff),
        .in_frame (s_q.in_frame),
        .busy     (s_q.busy),
        .start_ok (start_ok)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            // Flush completes: every field returns to empty, busy clears.
            s_d = '0;
        end else begin
            if (keep_w) begin
                s_d.wptr = s_q.wptr + 1'b1;
            end
            if (pop_w) begin
                s_d.rptr = s_q.rptr + 1'b1;
            end
            s_d.level  = s_q.level + LVL_W'(keep_w) - LVL_W'(pop_w);
            s_d.frames = s_q.frames + LVL_W'(keep_w && wr_last)
                                    - LVL_W'(pop_w && head[DATA_W]);

            if (pop_w && head[DATA_W]) begin
                s_d.in_frame = 1'b0;
            end else if (uf_evt) begin
                s_d.in_frame = 1'b0;
            end else if (start_ok) begin
                s_d.in_frame = 1'b1;
            end

            if (uf_evt) begin
                s_d.uflow = 1'b1;
                s_d.drop  = !(wr_fire && wr_last);
            end else if (s_q.drop && wr_fire && wr_last) begin
                s_d.drop = 1'b0;
            end

            if (flush_req) begin
                s_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid   = s_q.in_frame && !empty_w && !s_q.busy;
    assign rd_data    = head[DATA_W-1:0];
    assign rd_last    = head[DATA_W];
    assign fill_level = s_q.level;
    assign frame_cnt  = s_q.frames;
    assign underflow  = s_q.uflow;
    assign flush_busy = s_q.busy;

endmodule

// File: rtl/txq_fifo_chk.sv
module txq_fifo_chk #(
    parameter int DEPTH = 256,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             store_fwd,
    input logic             csum_en,
    input logic             osf_en,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic             underflow,
    input logic             flush_busy,
    input logic [LVL_W-1:0] fill_level,
    input logic [LVL_W-1:0] frame_cnt
);

    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL);

    a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == FULL) |-> !wr_ready);

    a_r7_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> !flush_busy);

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> (fill_level == '0 && frame_cnt == '0 && !underflow));

    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (!rd_valid && !wr_ready));

    a_r3_sf_whole_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_valid) && $past(store_fwd || csum_en)) |-> ($past(frame_cnt) != '0));

    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flush_busy) |=> underflow);

    a_r8_single_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!osf_en && frame_cnt != '0) |-> !wr_ready);

    a_r10_frames_le_level: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= fill_level);

endmodule

bind txq_fifo txq_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_fwd  (store_fwd),
    .csum_en    (csum_en),
    .osf_en     (osf_en),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .underflow  (underflow),
    .flush_busy (flush_busy),
    .fill_level (fill_level),
    .frame_cnt  (frame_cnt)
);

// File: tb/txq_fifo_tb.sv
module txq_fifo_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 256;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          store_fwd = 1'b0;
    logic [2:0]    thr_code = 3'd0;
    logic          csum_en = 1'b0;
    logic          osf_en = 1'b1;
    logic          flush_req = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_last = 1'b0;
    logic          wr_ready;
    logic          rd_ready = 1'b0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_last;
    logic [LW-1:0] fill_level;
    logic [LW-1:0] frame_cnt;
    logic          underflow;
    logic          flush_busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txq_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .store_fwd(store_fwd), .thr_code(thr_code),
        .csum_en(csum_en), .osf_en(osf_en), .flush_req(flush_req),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .wr_ready(wr_ready), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last), .fill_level(fill_level),
        .frame_cnt(frame_cnt), .underflow(underflow), .flush_busy(flush_busy)
    );

    task automatic eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int thr_of(input int code);
        if (code >= 4) return 256;
        if (code == 3) return 192;
        return 32 << code;
    endfunction

    // Writes n bytes base, base+1, ...; marks the final one when last_end.
    task automatic push_run(input int n, input int base, input bit last_end);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = DW'(base + i);
            wr_last  = last_end && (i == n - 1);
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    task automatic idle_edge();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R5: reads n bytes and checks order and end marker.
    task automatic drain(input int n, input int base, input bit last_end);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eq("R5 rd_valid", int'(rd_valid), 1);
            eq("R5 rd_data", int'(rd_data), (base + i) & 8'hFF);
            eq("R5 rd_last", int'(rd_last), int'(last_end && (i == n - 1)));
            rd_ready = 1'b1;
        end
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    // R7: flush with one-cycle busy and cleared state afterwards.
    task automatic do_flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        eq("R7 flush_busy set", int'(flush_busy), 1);
        eq("R7 wr_ready during flush", int'(wr_ready), 0);
        eq("R7 rd_valid during flush", int'(rd_valid), 0);
        @(negedge clk);
        eq("R7 flush_busy cleared", int'(flush_busy), 0);
        eq("R7 level after flush", int'(fill_level), 0);
        eq("R7 frames after flush", int'(frame_cnt), 0);
        eq("R7 underflow after flush", int'(underflow), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        eq("R1 fill_level", int'(fill_level), 0);
        eq("R1 frame_cnt", int'(frame_cnt), 0);
        eq("R1 underflow", int'(underflow), 0);
        eq("R1 flush_busy", int'(flush_busy), 0);
        eq("R1 rd_valid", int'(rd_valid), 0);
        eq("R1 wr_ready", int'(wr_ready), 1);

        // R2 / R6 / R9: sweep of every threshold code in cut-through mode
        for (int code = 0; code < 8; code++) begin
            int thr;
            thr = thr_of(code);
            thr_code = 3'(code);
            push_run(thr - 1, code * 16, 1'b0);
            idle_edge();
            eq("R2 idle below threshold", int'(rd_valid), 0);
            eq("R9 level below threshold", int'(fill_level), thr - 1);
            push_run(1, code * 16 + thr - 1, 1'b0);
            idle_edge();
            eq("R2 start at threshold", int'(rd_valid), 1);
            eq("R9 level at threshold", int'(fill_level), thr);
            eq("R9 wr_ready vs full", int'(wr_ready), int'(thr != DEPTH));
            drain(thr, code * 16, 1'b0);
            // pull once more from the empty buffer mid-frame
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            eq("R6 underflow set", int'(underflow), 1);
            eq("R6 rd_valid dropped", int'(rd_valid), 0);
            push_run(5, 8'hA0, 1'b1);
            idle_edge();
            eq("R6 tail discarded level", int'(fill_level), 0);
            eq("R6 tail discarded frames", int'(frame_cnt), 0);
            push_run(3, 8'h50, 1'b1);
            idle_edge();
            eq("R10 next frame counted", int'(frame_cnt), 1);
            eq("R2 complete frame starts", int'(rd_valid), 1);
            drain(3, 8'h50, 1'b1);
            eq("R6 underflow sticky", int'(underflow), 1);
            do_flush();
        end

        // R3: store-and-forward ignores the threshold
        store_fwd = 1'b1;
        thr_code  = 3'd0;
        push_run(40, 8'h10, 1'b0);
        idle_edge();
        eq("R3 no start without last", int'(rd_valid), 0);
        eq("R10 no complete frame", int'(frame_cnt), 0);
        push_run(1, 8'h38, 1'b1);
        idle_edge();
        eq("R3 start after last", int'(rd_valid), 1);
        eq("R10 one frame", int'(frame_cnt), 1);
        drain(41, 8'h10, 1'b1);
        eq("R5 idle after frame end", int'(rd_valid), 0);
        eq("R10 frame drained", int'(frame_cnt), 0);
        eq("R9 level empty", int'(fill_level), 0);
        eq("R6 no underflow in store-and-forward", int'(underflow), 0);

        // R4: checksum insertion forces store-and-forward
        store_fwd = 1'b0;
        csum_en   = 1'b1;
        push_run(40, 8'h20, 1'b0);
        idle_edge();
        eq("R4 no start without last", int'(rd_valid), 0);
        push_run(1, 8'h48, 1'b1);
        idle_edge();
        eq("R4 start after last", int'(rd_valid), 1);
        drain(41, 8'h20, 1'b1);
        csum_en = 1'b0;

        // R8: second-frame option
        store_fwd = 1'b1;
        osf_en    = 1'b0;
        push_run(4, 8'h60, 1'b1);
        idle_edge();
        eq("R8 wr_ready held off", int'(wr_ready), 0);
        drain(4, 8'h60, 1'b1);
        eq("R8 wr_ready after drain", int'(wr_ready), 1);
        osf_en = 1'b1;
        push_run(4, 8'h70, 1'b1);
        push_run(4, 8'h80, 1'b1);
        eq("R10 two frames", int'(frame_cnt), 2);
        eq("R8 wr_ready with second frame", int'(wr_ready), 1);
        drain(4, 8'h70, 1'b1);
        drain(4, 8'h80, 1'b1);
        eq("R10 all drained", int'(frame_cnt), 0);

        // R7: flush in the middle of a partial frame, then clean reuse
        push_run(10, 8'h90, 1'b0);
        eq("R9 partial level", int'(fill_level), 10);
        do_flush();
        push_run(2, 8'hC0, 1'b1);
        idle_edge();
        drain(2, 8'hC0, 1'b1);
        store_fwd = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule